// File: doc/BRIEF.md
# Processor Debug Register Access Target

This block sits inside a processor core and answers a simple debug module interface (DMI) master. The master presents a 4-bit address, 64-bit write data, a request and a write-enable. The block answers with an acknowledge and, for reads, 64-bit read data. Through a small register map the master can halt the core, let it run again, advance it by exactly one instruction, and inspect its state. The readable state is the next instruction address, the machine state register, the condition register and the fixed-point exception flags. Any general register can be read by first writing its number to an index address and then reading a data address.

A stand-in core model replaces the real pipeline. While it runs, it retires one instruction per clock. Each retirement adds 4 to the next instruction address and 1 to a retirement counter, and the other visible state is derived from that counter. As a result, every value the master reads is consistent with every other value read in the same stopped state.

Top module: `dbg_access_target`

## Requirements
- R1: After reset, acknowledge is low and the core is running, so status bit 1 (value 0x2) reads as 0.
- R2: A request is accepted only when acknowledge is low. Acknowledge rises one cycle after acceptance, stays high while request stays high, and falls the cycle after request drops. A request held high is accepted only once. On a read, the data output is valid while acknowledge is high.
- R3: Writing address 0 with bit 0 set stops the core. Status (address 1) then reads with bit 1 set, and the next instruction address stays constant.
- R4: Writing address 0 with bit 1 set resumes the core. Status bit 1 clears, and the next instruction address advances again.
- R5: Writing address 0 with bit 3 set while stopped retires exactly one instruction: the address advances by 4 and the condition register by 1, after which the core is stopped again. The same write while running has no effect and the core keeps running.
- R6: When one control write sets several command bits, stop takes priority over resume, and resume takes priority over step.
- R7: Address 2 returns the next instruction address, which equals RESET_NIA + 4 × retired count. Address 3 returns the MSR_VALUE parameter. Address 8 returns the condition register, which is the 32-bit retired count zero-extended.
- R8: Address 9 returns the exception flags taken from retired-count bits 0..4, packed as follows: summary overflow at bit 0, carry at bit 2, 32-bit carry at bit 3, overflow at bit 4, and 32-bit overflow at bit 5. All other bits are zero.
- R9: A write to address 4 stores a register index, and a read of address 4 returns it. A read of address 5 returns {16'hC0DE, 16-bit index, 32-bit retired count} when the index is below 32, and zero otherwise.
- R10: Reads of addresses 6, 7 and 10 to 15 return zero and are acknowledged. Writes to read-only addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dmi_addr | input | 4 | Register address |
| dmi_wdata | input | 64 | Write data |
| dmi_req | input | 1 | Transaction request |
| dmi_we | input | 1 | 1 = write, 0 = read |
| dmi_rdata | output | 64 | Read data, valid while acknowledge is high |
| dmi_ack | output | 1 | Acknowledge |

## Verification
A single control write can carry several commands, so stop, resume and step can all land on the same clock edge. The bench provokes this with the words 0x3 while running, 0xA while stopped and 0x9 while stopped. It judges the outcome by reading the status register and comparing next-instruction-address reads before and after each write. The handshake and a step can also coincide: a step write is held with request high for several cycles, and the address must then have moved by exactly 4, which shows the step was accepted only once.

// File: rtl/dbg_access_pkg.sv
package dbg_access_pkg;
    localparam int unsigned ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 4'd0,
        REG_STAT  = 4'd1,
        REG_NIA   = 4'd2,
        REG_MSR   = 4'd3,
        REG_INDEX = 4'd4,
        REG_GDATA = 4'd5,
        REG_COND  = 4'd8,
        REG_XFLAG = 4'd9
    } dbg_reg_e;

    localparam int unsigned CTL_STOP_BIT   = 0;
    localparam int unsigned CTL_RESUME_BIT = 1;
    localparam int unsigned CTL_STEP_BIT   = 3;
    localparam int unsigned STAT_HALT_BIT  = 1;

    typedef struct packed {
        logic stop;
        logic resume;
        logic step;
    } ctl_cmd_t;
endpackage

// File: rtl/dbg_core_model.sv
module dbg_core_model
    import dbg_access_pkg::*;
#(
    parameter int unsigned          DATA_W    = 64,
    parameter int unsigned          CNT_W     = 32,
    parameter logic [DATA_W-1:0]    RESET_NIA = 64'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_cmd_t          cmd,
    output logic              stopped_o,
    output logic [DATA_W-1:0] nia_o,
    output logic [CNT_W-1:0]  retired_o
);
    localparam logic [DATA_W-1:0] INSN_BYTES = DATA_W'(4);

    typedef struct packed {
        logic              run;
        logic              step;
        logic [DATA_W-1:0] nia;
        logic [CNT_W-1:0]  cnt;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     exec;

    always_comb begin
        st_d      = st_q;
        exec      = st_q.run | st_q.step;
        stopped_o = ~st_q.run & ~st_q.step;
        if (exec) begin
            st_d.nia = st_q.nia + INSN_BYTES;
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        st_d.step = 1'b0;
        if (cmd.stop) begin
            st_d.run = 1'b0;
        end else if (cmd.resume) begin
            st_d.run = 1'b1;
        end else if (cmd.step && stopped_o) begin
            st_d.step = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b1, step: 1'b0, nia: RESET_NIA, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign nia_o     = st_q.nia;
    assign retired_o = st_q.cnt;

    assert_step_restops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.step && !cmd.resume |=> stopped_o);
    assert_step_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.step |=> nia_o == $past(nia_o) + INSN_BYTES);
    assert_halt_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stopped_o && !cmd.resume && !cmd.step |=> $stable(nia_o));
    assert_stop_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.stop |=> stopped_o);
endmodule

// File: rtl/dbg_read_mux.sv
module dbg_read_mux
    import dbg_access_pkg::*;
#(
    parameter int unsigned       DATA_W    = 64,
    parameter int unsigned       CNT_W     = 32,
    parameter int unsigned       IDX_W     = 8,
    parameter int unsigned       NUM_GPR   = 32,
    parameter logic [DATA_W-1:0] MSR_VALUE = 64'h8000_0000_0000_1033
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              stopped,
    input  logic [DATA_W-1:0] nia,
    input  logic [CNT_W-1:0]  retired,
    input  logic [IDX_W-1:0]  index,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] gpr_val;
    logic [DATA_W-1:0] xflag_val;

    always_comb begin
        gpr_val = '0;
        if (32'(index) < NUM_GPR) begin
            gpr_val = DATA_W'({16'hC0DE, 16'(index), 32'(retired)});
        end
        xflag_val    = '0;
        xflag_val[0] = retired[0];
        xflag_val[2] = retired[1];
        xflag_val[3] = retired[2];
        xflag_val[4] = retired[3];
        xflag_val[5] = retired[4];
    end

    always_comb begin
        rdata = '0;
        case (addr)
            REG_STAT:  rdata[STAT_HALT_BIT] = stopped;
            REG_NIA:   rdata = nia;
            REG_MSR:   rdata = MSR_VALUE;
            REG_INDEX: rdata = DATA_W'(index);
            REG_GDATA: rdata = gpr_val;
            REG_COND:  rdata = DATA_W'(retired);
            REG_XFLAG: rdata = xflag_val;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/dbg_access_target.sv
module dbg_access_target
    import dbg_access_pkg::*;
#(
    parameter int unsigned       DATA_W    = 64,
    parameter int unsigned       IDX_W     = 8,
    parameter int unsigned       NUM_GPR   = 32,
    parameter logic [DATA_W-1:0] RESET_NIA = 64'h1000,
    parameter logic [DATA_W-1:0] MSR_VALUE = 64'h8000_0000_0000_1033
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        dmi_addr,
    input  logic [DATA_W-1:0] dmi_wdata,
    input  logic              dmi_req,
    input  logic              dmi_we,
    output logic [DATA_W-1:0] dmi_rdata,
    output logic              dmi_ack
);
    localparam int unsigned CNT_W = 32;

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] rdata;
        logic [IDX_W-1:0]  index;
    } port_st_t;

    port_st_t          ps_d, ps_q;
    logic              accept;
    ctl_cmd_t          cmd;
    logic              core_stopped;
    logic [DATA_W-1:0] core_nia;
    logic [CNT_W-1:0]  core_retired;
    logic [DATA_W-1:0] mux_data;
    logic              unmapped;

    dbg_core_model #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RESET_NIA(RESET_NIA)) u_core (
        .clk(clk), .rst_n(rst_n), .cmd(cmd),
        .stopped_o(core_stopped), .nia_o(core_nia), .retired_o(core_retired)
    );

    dbg_read_mux #(.DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W),
                   .NUM_GPR(NUM_GPR), .MSR_VALUE(MSR_VALUE)) u_mux (
        .addr(dmi_addr), .stopped(core_stopped), .nia(core_nia),
        .retired(core_retired), .index(ps_q.index), .rdata(mux_data)
    );

    always_comb begin
        ps_d   = ps_q;
        accept = dmi_req & ~ps_q.ack;
        cmd    = '0;
        if (!dmi_req) begin
            ps_d.ack = 1'b0;
        end
        if (accept) begin
            ps_d.ack = 1'b1;
            if (dmi_we) begin
                ps_d.rdata = '0;
                if (dmi_addr == REG_INDEX) begin
                    ps_d.index = dmi_wdata[IDX_W-1:0];
                end
                if (dmi_addr == REG_CTRL) begin
                    cmd.stop   = dmi_wdata[CTL_STOP_BIT];
                    cmd.resume = dmi_wdata[CTL_RESUME_BIT];
                    cmd.step   = dmi_wdata[CTL_STEP_BIT];
                end
            end else begin
                ps_d.rdata = mux_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign dmi_ack   = ps_q.ack;
    assign dmi_rdata = ps_q.rdata;
    assign unmapped  = (dmi_addr == 4'd6) || (dmi_addr == 4'd7) || (dmi_addr >= 4'd10);

    assert_ack_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dmi_req |=> !dmi_ack);
    assert_ack_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dmi_ack && dmi_req |=> dmi_ack && $stable(dmi_rdata));
    assert_ack_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmi_ack) |-> $past(dmi_req));
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !dmi_we && unmapped |=> dmi_rdata == '0);
endmodule

// File: tb/tb_dbg_access_target.sv
module tb_dbg_access_target;
    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] RST_NIA    = 64'h1000;
    localparam logic [63:0] MSR_V      = 64'h8000_0000_0000_1033;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  dmi_addr = '0;
    logic [63:0] dmi_wdata = '0;
    logic        dmi_req = 1'b0;
    logic        dmi_we = 1'b0;
    logic [63:0] dmi_rdata;
    logic        dmi_ack;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_access_target #(.RESET_NIA(RST_NIA), .MSR_VALUE(MSR_V)) dut (
        .clk(clk), .rst_n(rst_n), .dmi_addr(dmi_addr), .dmi_wdata(dmi_wdata),
        .dmi_req(dmi_req), .dmi_we(dmi_we), .dmi_rdata(dmi_rdata), .dmi_ack(dmi_ack)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [3:0] a, input logic w, input logic [63:0] d,
                        input int hold, output logic [63:0] r);
        int n;
        n = 0;
        @(negedge clk);
        dmi_addr = a; dmi_we = w; dmi_wdata = d; dmi_req = 1'b1;
        do begin
            @(negedge clk);
            n++;
        end while (!dmi_ack && n < 50);
        r = dmi_rdata;
        repeat (hold) @(negedge clk);
        dmi_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, output logic [63:0] r);
        xfer(a, 1'b0, 64'd0, 0, r);
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        logic [63:0] r;
        xfer(a, 1'b1, d, 0, r);
    endtask

    task automatic t_reset();
        logic [63:0] r;
        chk("R1 ack after reset", 64'(dmi_ack), 64'd0);
        rd(4'd1, r);
        chk("R1 running after reset", r & 64'h2, 64'd0);
    endtask

    task automatic t_handshake();
        @(negedge clk);
        dmi_addr = 4'd3; dmi_we = 1'b0; dmi_req = 1'b1;
        chk("R2 ack low before edge", 64'(dmi_ack), 64'd0);
        @(negedge clk);
        chk("R2 ack one cycle after request", 64'(dmi_ack), 64'd1);
        chk("R2 data valid with ack", dmi_rdata, MSR_V);
        repeat (3) @(negedge clk);
        chk("R2 ack held while request high", 64'(dmi_ack), 64'd1);
        dmi_req = 1'b0;
        @(negedge clk);
        chk("R2 ack drops after request", 64'(dmi_ack), 64'd0);
    endtask

    task automatic t_stop();
        logic [63:0] r, a0, a1;
        wr(4'd0, 64'h1);
        rd(4'd1, r);
        chk("R3 stopped status", r & 64'h2, 64'h2);
        rd(4'd2, a0);
        repeat (5) @(negedge clk);
        rd(4'd2, a1);
        chk("R3 NIA frozen", a1, a0);
    endtask

    task automatic t_state();
        logic [63:0] c, r;
        rd(4'd8, c);
        rd(4'd2, r);
        chk("R7 NIA matches retired count", r, RST_NIA + 64'(c[31:0]) * 64'd4);
        chk("R7 CR upper bits zero", c >> 32, 64'd0);
        rd(4'd3, r);
        chk("R7 MSR value", r, MSR_V);
        rd(4'd9, r);
        chk("R8 flag packing", r, {58'd0, c[4], c[3], c[2], c[1], 1'b0, c[0]});
        wr(4'd4, 64'd7);
        rd(4'd4, r);
        chk("R9 index readback", r, 64'd7);
        rd(4'd5, r);
        chk("R9 GPR 7", r, {16'hC0DE, 16'd7, c[31:0]});
        wr(4'd4, 64'd31);
        rd(4'd5, r);
        chk("R9 GPR 31", r, {16'hC0DE, 16'd31, c[31:0]});
        wr(4'd4, 64'd32);
        rd(4'd5, r);
        chk("R9 index 32 reads zero", r, 64'd0);
        wr(4'd4, 64'd200);
        rd(4'd5, r);
        chk("R9 index 200 reads zero", r, 64'd0);
    endtask

    task automatic t_unmapped();
        logic [63:0] r, a0;
        rd(4'd6, r);  chk("R10 addr 6 zero", r, 64'd0);
        rd(4'd12, r); chk("R10 addr 12 zero", r, 64'd0);
        rd(4'd15, r); chk("R10 addr 15 zero", r, 64'd0);
        rd(4'd2, a0);
        wr(4'd2, 64'hDEAD);
        wr(4'd8, 64'hBEEF);
        rd(4'd2, r);
        chk("R10 write to NIA ignored", r, a0);
        rd(4'd1, r);
        chk("R10 still stopped", r & 64'h2, 64'h2);
    endtask

    task automatic t_step();
        logic [63:0] a0, c0, r;
        rd(4'd2, a0);
        rd(4'd8, c0);
        xfer(4'd0, 1'b1, 64'h8, 4, r);
        repeat (3) @(negedge clk);
        rd(4'd1, r);
        chk("R5 stopped after step", r & 64'h2, 64'h2);
        rd(4'd2, r);
        chk("R5 NIA advanced once by 4", r, a0 + 64'd4);
        rd(4'd8, r);
        chk("R5 CR advanced once", r, c0 + 64'd1);
    endtask

    task automatic t_resume_and_running_step();
        logic [63:0] a0, a1, r;
        wr(4'd0, 64'h2);
        rd(4'd1, r);
        chk("R4 running after resume", r & 64'h2, 64'd0);
        rd(4'd2, a0);
        rd(4'd2, a1);
        chk("R4 NIA advancing", 64'(a1 > a0), 64'd1);
        wr(4'd0, 64'h8);
        repeat (3) @(negedge clk);
        rd(4'd1, r);
        chk("R5 step while running ignored", r & 64'h2, 64'd0);
    endtask

    task automatic t_priority();
        logic [63:0] a0, r;
        wr(4'd0, 64'h3);
        rd(4'd1, r);
        chk("R6 stop beats resume", r & 64'h2, 64'h2);
        wr(4'd0, 64'hA);
        repeat (3) @(negedge clk);
        rd(4'd1, r);
        chk("R6 resume beats step", r & 64'h2, 64'd0);
        wr(4'd0, 64'h1);
        rd(4'd2, a0);
        wr(4'd0, 64'h9);
        repeat (3) @(negedge clk);
        rd(4'd2, r);
        chk("R6 stop beats step", r, a0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_stop();
        t_state();
        t_unmapped();
        t_step();
        t_resume_and_running_step();
        t_priority();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule